// File: doc/BRIEF.md
# Dot Matrix Refresh Scanner

This block drives a multiplexed display of four character cells. Each cell is a dot matrix five columns wide and seven rows tall. A scan tick moves the scanner one step through a fixed order. For every cell, the scanner visits its rows from top to bottom before it moves on to the next cell. On each step it takes the 7-bit character code of the selected cell and reads the five column bits of the current row from a 128-entry glyph table. It then registers a row code, a one-hot cell select and the column bits. Blanking and brightness gating are handled outside the block.

Each row period lasts a fixed number of scan ticks, called sub-phases (two by default). A glyph row holds the same column bits for the whole row period. A global cursor-enable input and a 4-bit field of per-cell cursor flags can replace a cell's glyph with a cursor that lights every dot. Cursor columns are driven only on even sub-phases, so each cursor dot is lit for half the time of a glyph dot. The glyph table is a function that can be swapped out. It defines a few characters explicitly, returns a blank row for space, and returns a hollow-frame placeholder for every other code.

The character codes and the cursor inputs are plain levels. The block samples them only on the clock edge where the scan tick is high. An upstream register file can therefore update them at any time.

Top module: `dmx_refresh_scanner`

## Requirements
- R1: While reset is asserted, and after reset until the first scan tick, `row_sel`, `digit_sel` and `col_data` are all zero. After reset the scan position is cell 0, row 0, sub-phase 0.
- R2: On a clock edge where `scan_tick` is 1, the outputs take the value for the current scan position and the position then advances. On edges without a tick, the outputs do not change.
- R3: The sub-phase counts 0..1 and advances first. The row then counts 0..6 and wraps to 0. After the row wrap, the cell counts 0..3 and wraps to 0. One frame is 56 ticks. `row_sel` carries the row number, and `digit_sel` has only bit d set for cell d.
- R4: `col_data` bit 4 is the leftmost column. Glyph rows, listed top (row 0) to bottom (row 6):
  - 'A' (0x41): 01110,10001,10001,11111,10001,10001,10001
  - 'H' (0x48): 10001,10001,10001,11111,10001,10001,10001
  - '0' (0x30): 01110,10001,10011,10101,11001,10001,01110
  - '1' (0x31): 00100,01100,00100,00100,00100,00100,01110
  - '-' (0x2D): only row 3 is 11111; every other row is 00000
  - space (0x20): 00000 on every row
  - every other code: 11111 on rows 0 and 6, and 10001 on rows 1 to 5
- R5: When `cursor_en` is 1 and `cursor_flags[d]` is 1, the rows of cell d show 11111 on sub-phase 0 and 00000 on sub-phase 1.
- R6: When `cursor_en` is 0, the glyph of the stored code is shown whatever the values of `cursor_flags`.
- R7: When `cursor_en` is 1 and `cursor_flags[d]` is 0, cell d shows its glyph.
- R8: Changes to `char_codes`, `cursor_flags` or `cursor_en` between ticks do not change the outputs. The new values take effect only on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_tick | input | 1 | Advance the scan by one sub-phase |
| cursor_en | input | 1 | Global cursor enable |
| char_codes | input | 28 | Four 7-bit codes; cell d occupies bits [7d+6:7d] |
| cursor_flags | input | 4 | Per-cell cursor flag; bit d belongs to cell d |
| row_sel | output | 3 | Row being driven, 0 = top |
| digit_sel | output | 4 | One-hot cell select, all zero before the first tick |
| col_data | output | 5 | Column bits of the driven row, bit 4 = left |

## Verification
The hardest situation to reach is a cell with its cursor enabled while its neighbours are in other cursor states. The stimulus must also hit the odd sub-phase, where the cursor row goes dark even though the glyph beneath it has lit dots. The sweep runs one full frame per character code. The cursor enable and the cursor flags are taken from bits of that code, so all 32 combinations of enable and flags occur across the sweep. Each cell holds a different code, so the full code space passes through every cell. A separate step changes the inputs between ticks and watches the outputs stay unchanged. Another step resets the block in the middle of a frame.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int GLYPH_COLS = 5;
  localparam int GLYPH_ROWS = 7;
  localparam int CODE_W     = 7;
  localparam int CELL_BITS  = GLYPH_COLS * GLYPH_ROWS;

  typedef logic [GLYPH_COLS-1:0] col_t;
  typedef logic [CODE_W-1:0]     code_t;
  typedef logic [CELL_BITS-1:0]  bitmap_t;

  typedef enum logic [0:0] {
    SRC_GLYPH  = 1'b0,
    SRC_CURSOR = 1'b1
  } cell_src_e;
endpackage

// File: rtl/dmx_scan_seq.sv
module dmx_scan_seq #(
  parameter int NUM_DIGITS = 4,
  parameter int NUM_ROWS   = 7,
  parameter int SUB_PHASES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  output logic [(NUM_DIGITS>1 ? $clog2(NUM_DIGITS) : 1)-1:0] digit,
  output logic [(NUM_ROWS>1 ? $clog2(NUM_ROWS) : 1)-1:0]     row,
  output logic [(SUB_PHASES>1 ? $clog2(SUB_PHASES) : 1)-1:0] phase
);
  localparam int DIG_W = NUM_DIGITS > 1 ? $clog2(NUM_DIGITS) : 1;
  localparam int ROW_W = NUM_ROWS   > 1 ? $clog2(NUM_ROWS)   : 1;
  localparam int PH_W  = SUB_PHASES > 1 ? $clog2(SUB_PHASES) : 1;
  localparam logic [DIG_W-1:0] DIG_LAST = DIG_W'(NUM_DIGITS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SUB_PHASES - 1);

  logic ph_wrap, row_wrap;
  assign ph_wrap  = (phase == PH_LAST);
  assign row_wrap = ph_wrap && (row == ROW_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      row   <= '0;
      digit <= '0;
    end else if (tick) begin
      phase <= ph_wrap ? '0 : phase + 1'b1;
      if (ph_wrap) row <= (row == ROW_LAST) ? '0 : row + 1'b1;
      if (row_wrap) digit <= (digit == DIG_LAST) ? '0 : digit + 1'b1;
    end
  end

  a_r3_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
    row <= ROW_LAST);
  a_r3_row_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && row == ROW_LAST && phase == PH_LAST) |=> (row == '0));
  a_r3_row_held_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && phase != PH_LAST) |=> (row == $past(row) && digit == $past(digit)));
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(phase) && $stable(row) && $stable(digit)));
endmodule

// File: rtl/dmx_glyph_rom.sv
module dmx_glyph_rom
  import dmx_pkg::*;
(
  input  code_t      code,
  input  logic [2:0] row,
  output col_t       cols
);
  bitmap_t bm;

  // Bitmap layout: {row6, row5, ..., row0}, each row with the left column at bit 4.
  always_comb begin
    case (code)
      7'h20: bm = '0;
      7'h2D: bm = {5'b00000, 5'b00000, 5'b00000, 5'b11111, 5'b00000, 5'b00000, 5'b00000};
      7'h30: bm = {5'b01110, 5'b10001, 5'b11001, 5'b10101, 5'b10011, 5'b10001, 5'b01110};
      7'h31: bm = {5'b01110, 5'b00100, 5'b00100, 5'b00100, 5'b00100, 5'b01100, 5'b00100};
      7'h41: bm = {5'b10001, 5'b10001, 5'b10001, 5'b11111, 5'b10001, 5'b10001, 5'b01110};
      7'h48: bm = {5'b10001, 5'b10001, 5'b10001, 5'b11111, 5'b10001, 5'b10001, 5'b10001};
      default: begin
        for (int r = 0; r < GLYPH_ROWS; r++) begin
          bm[r*GLYPH_COLS +: GLYPH_COLS] =
            (r == 0 || r == GLYPH_ROWS-1) ? 5'b11111 : 5'b10001;
        end
      end
    endcase
  end

  always_comb begin
    cols = '0;
    for (int r = 0; r < GLYPH_ROWS; r++) begin
      if (row == 3'(r)) cols = bm[r*GLYPH_COLS +: GLYPH_COLS];
    end
  end
endmodule

// File: rtl/dmx_cell_mux.sv
module dmx_cell_mux
  import dmx_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int DIG_W      = 2
) (
  input  logic [NUM_DIGITS*CODE_W-1:0] codes,
  input  logic [NUM_DIGITS-1:0]        flags,
  input  logic                         cursor_en,
  input  logic [DIG_W-1:0]             digit,
  input  logic                         phase_odd,
  output code_t                        code_sel,
  output cell_src_e                    src,
  output logic                         cursor_lit,
  output logic [NUM_DIGITS-1:0]        sel_onehot
);
  code_t code_arr [NUM_DIGITS];

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_cell
    assign code_arr[g]   = codes[g*CODE_W +: CODE_W];
    assign sel_onehot[g] = (digit == DIG_W'(g));
  end

  always_comb begin
    code_sel = '0;
    src      = SRC_GLYPH;
    for (int d = 0; d < NUM_DIGITS; d++) begin
      if (sel_onehot[d]) begin
        code_sel = code_arr[d];
        if (cursor_en && flags[d]) src = SRC_CURSOR;
      end
    end
  end

  assign cursor_lit = !phase_odd;
endmodule

// File: rtl/dmx_refresh_scanner.sv
module dmx_refresh_scanner
  import dmx_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int SUB_PHASES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scan_tick,
  input  logic                         cursor_en,
  input  logic [NUM_DIGITS*CODE_W-1:0] char_codes,
  input  logic [NUM_DIGITS-1:0]        cursor_flags,
  output logic [2:0]                   row_sel,
  output logic [NUM_DIGITS-1:0]        digit_sel,
  output logic [GLYPH_COLS-1:0]        col_data
);
  localparam int DIG_W = NUM_DIGITS > 1 ? $clog2(NUM_DIGITS) : 1;
  localparam int PH_W  = SUB_PHASES > 1 ? $clog2(SUB_PHASES) : 1;

  logic [DIG_W-1:0]      digit;
  logic [2:0]            row;
  logic [PH_W-1:0]       phase;
  code_t                 code_sel;
  cell_src_e             src;
  logic                  cursor_lit;
  logic [NUM_DIGITS-1:0] sel_onehot;
  col_t                  glyph_cols;
  col_t                  col_next;

  dmx_scan_seq #(
    .NUM_DIGITS(NUM_DIGITS),
    .NUM_ROWS  (GLYPH_ROWS),
    .SUB_PHASES(SUB_PHASES)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (scan_tick),
    .digit(digit),
    .row  (row),
    .phase(phase)
  );

  dmx_cell_mux #(
    .NUM_DIGITS(NUM_DIGITS),
    .DIG_W     (DIG_W)
  ) u_mux (
    .codes     (char_codes),
    .flags     (cursor_flags),
    .cursor_en (cursor_en),
    .digit     (digit),
    .phase_odd (phase[0]),
    .code_sel  (code_sel),
    .src       (src),
    .cursor_lit(cursor_lit),
    .sel_onehot(sel_onehot)
  );

  dmx_glyph_rom u_rom (
    .code(code_sel),
    .row (row),
    .cols(glyph_cols)
  );

  assign col_next = (src == SRC_CURSOR) ? {GLYPH_COLS{cursor_lit}} : glyph_cols;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_sel   <= '0;
      digit_sel <= '0;
      col_data  <= '0;
    end else if (scan_tick) begin
      row_sel   <= row;
      digit_sel <= sel_onehot;
      col_data  <= col_next;
    end
  end

  a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (row_sel == '0 && digit_sel == '0 && col_data == '0));
  a_r2_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_tick |=> ($stable(col_data) && $stable(row_sel) && $stable(digit_sel)));
  a_r3_select_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(digit_sel));
  a_r3_select_active: assert property (@(posedge clk) disable iff (!rst_n)
    scan_tick |=> $onehot(digit_sel));
  a_r5_cursor_lit: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_tick && cursor_en && cursor_flags[digit] && !phase[0])
      |=> (col_data == {GLYPH_COLS{1'b1}}));
  a_r5_cursor_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_tick && cursor_en && cursor_flags[digit] && phase[0])
      |=> (col_data == '0));
endmodule

// File: tb/dmx_refresh_scanner_test.sv
module dmx_refresh_scanner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_tick = 1'b0;
  logic        cursor_en = 1'b0;
  logic [27:0] char_codes = '0;
  logic [3:0]  cursor_flags = '0;
  logic [2:0]  row_sel;
  logic [3:0]  digit_sel;
  logic [4:0]  col_data;

  int checks = 0;
  int fails  = 0;
  int k      = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dmx_refresh_scanner uut (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .cursor_en(cursor_en),
    .char_codes(char_codes), .cursor_flags(cursor_flags),
    .row_sel(row_sel), .digit_sel(digit_sel), .col_data(col_data)
  );

  function automatic logic [4:0] glyph(input logic [6:0] c, input int r);
    logic [4:0] rows [7];
    case (c)
      7'h20: rows = '{5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000};
      7'h2D: rows = '{5'b00000, 5'b00000, 5'b00000, 5'b11111, 5'b00000, 5'b00000, 5'b00000};
      7'h30: rows = '{5'b01110, 5'b10001, 5'b10011, 5'b10101, 5'b11001, 5'b10001, 5'b01110};
      7'h31: rows = '{5'b00100, 5'b01100, 5'b00100, 5'b00100, 5'b00100, 5'b00100, 5'b01110};
      7'h41: rows = '{5'b01110, 5'b10001, 5'b10001, 5'b11111, 5'b10001, 5'b10001, 5'b10001};
      7'h48: rows = '{5'b10001, 5'b10001, 5'b10001, 5'b11111, 5'b10001, 5'b10001, 5'b10001};
      default: rows = '{5'b11111, 5'b10001, 5'b10001, 5'b10001, 5'b10001, 5'b10001, 5'b11111};
    endcase
    return rows[r];
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (tick %0d)", tag, act, exp, k);
    end
  endtask

  // Tick once with the current inputs and check the outputs for position k.
  task automatic tick_and_check();
    int ph, r, d;
    logic [6:0] c;
    logic [4:0] exp_col;
    string tag;
    ph = k % 2; r = (k / 2) % 7; d = (k / 14) % 4;
    c = char_codes[d*7 +: 7];
    if (cursor_en && cursor_flags[d]) begin
      exp_col = (ph == 0) ? 5'b11111 : 5'b00000; tag = "R5 cursor";
    end else begin
      exp_col = glyph(c, r);
      tag = cursor_en ? "R7 glyph unflagged" : (cursor_flags[d] ? "R6 flag ignored" : "R4 glyph");
    end
    @(negedge clk) scan_tick = 1'b1;
    @(negedge clk) scan_tick = 1'b0;
    check(row_sel == 3'(r) && digit_sel == 4'(1 << d), "R3 position",
          {row_sel, digit_sel}, {r[2:0], 4'(1 << d)});
    check(col_data == exp_col, tag, col_data, exp_col);
    k++;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [4:0]  h_col;
    logic [2:0]  h_row;
    logic [3:0]  h_dig;
    repeat (3) @(negedge clk);
    check(row_sel == 0 && digit_sel == 0 && col_data == 0, "R1 in reset",
          {row_sel, digit_sel, col_data}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(row_sel == 0 && digit_sel == 0 && col_data == 0, "R1 after reset",
          {row_sel, digit_sel, col_data}, 0);

    // Sweep every code through every cell; cursor enable and flags come from the code bits.
    for (int c = 0; c < 128; c++) begin
      for (int d = 0; d < 4; d++) char_codes[d*7 +: 7] = 7'((c + d * 37) % 128);
      cursor_flags = 4'(c);
      cursor_en    = c[4];
      for (int t = 0; t < 56; t++) tick_and_check();
    end

    // Named glyph frame with no cursor: 'A','H','0','1'.
    cursor_en = 1'b0; cursor_flags = 4'hF;
    char_codes = {7'h31, 7'h30, 7'h48, 7'h41};
    for (int t = 0; t < 56; t++) tick_and_check();

    // R8: inputs change between ticks; outputs must not move.
    for (int t = 0; t < 5; t++) tick_and_check();
    h_col = col_data; h_row = row_sel; h_dig = digit_sel;
    @(negedge clk);
    char_codes = {7'h2D, 7'h2D, 7'h2D, 7'h2D};
    cursor_en = 1'b1; cursor_flags = 4'hF;
    repeat (4) @(negedge clk);
    check(col_data == h_col && row_sel == h_row && digit_sel == h_dig, "R8 no tick",
          {row_sel, digit_sel, col_data}, {h_row, h_dig, h_col});
    cursor_flags = 4'h0;
    for (int t = 0; t < 60; t++) tick_and_check();

    // R1: reset mid-frame returns to cell 0, row 0, sub-phase 0.
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check(row_sel == 0 && digit_sel == 0 && col_data == 0, "R1 mid-frame reset",
          {row_sel, digit_sel, col_data}, 0);
    rst_n = 1'b1; k = 0;
    char_codes = {7'h41, 7'h41, 7'h41, 7'h41};
    cursor_en = 1'b0;
    for (int t = 0; t < 56; t++) tick_and_check();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule